// File: doc/BRIEF.md
# SDRAM Bank Command Monitor

This block watches a double-data-rate SDRAM command bus without driving it. On every clock where the clock-enable input has been high for two samples in a row, it turns the chip-select, row-strobe, column-strobe and write-enable pins into a command. It then judges that command against a small state machine kept for each bank. Column accesses that carry the auto-precharge flag are followed through two phases: a column-access phase, then a hidden row-close phase that ends with the bank idle. The burst, recovery and row timings are counted in clock cycles, with a separate down-counter in each bank.

Each command is judged in two ways: against the addressed bank's own state, and against the bursts that other banks have in flight. A legal column command to one bank cuts short a plain burst running in another bank. It is rejected if another bank still holds an auto-precharge access. A rejected command leaves every bank as it was, apart from the normal ageing of the timers. The monitor reports it with a one-cycle error pulse, an error code and the number of the bank that objected.

Top module: `bank_cmd_monitor`

## Requirements
- R1: With chip select low, the pins {row strobe, column strobe, write enable} decode as 111 no-op (code 1), 011 activate (2), 101 read (3), 100 write (4) and 010 precharge (5). Any other low-select pattern is code 6, and a high chip select is a deselect (code 0). The code appears on `cmd_out` one cycle after the command is sampled. Deselect, no-op and code 6 never raise an error.
- R2: A command is checked only when `cke` is high in the cycle it is sampled and was also high one cycle earlier. Otherwise `cmd_out` shows 7, no error is raised, and every bank state and timer holds. After reset all banks are idle and `cmd_out` is 7.
- R3: Bank states are coded 0 idle, 1 opening, 2 open, 3 read, 4 write, 5 read with auto-precharge, 6 write with auto-precharge, 7 closing. An activate to an idle bank makes it opening for TRCD cycles, then open. A read or write issued while the bank is opening is rejected with code 3.
- R4: A read or write to an idle or closing bank is rejected with code 1. An activate to a bank that is opening, open, reading or writing is rejected with code 2. A precharge to an idle or closing bank is accepted and changes nothing.
- R5: A plain read holds state 3 for CL+BL/2 cycles, and a plain write holds state 4 for 1+BL/2+TWR cycles; after either the bank is open again. A precharge to a bank in state 4 is rejected with code 5. A precharge to an opening, open or reading bank starts closing.
- R6: A read with auto-precharge holds state 5 for BL/2 cycles, then state 7 for TRP cycles, then the bank is idle.
- R7: A write with auto-precharge holds state 6 for 1+BL/2+TWR cycles, then state 7 for TRP cycles, then the bank is idle.
- R8: Any activate, read, write or precharge aimed at a bank in state 5 or 6 is rejected with code 6. An activate to a closing bank is rejected with code 4.
- R9: An accepted read or write to one bank returns any other bank in state 3 or 4 to open on the same edge.
- R10: A read or write to another bank while a bank is in state 5 or 6 is rejected with code 7, and the bank holding the auto-precharge access is the one reported. An activate or precharge to another bank stays legal.
- R11: A precharge with `ap` high addresses every bank at once. It is rejected as a whole if any bank is in state 4 (code 5) or in state 5 or 6 (code 6).
- R12: When a command is rejected, no bank takes it, `err_pulse` is high for one cycle and `err_bank` names the lowest-numbered objecting bank.
- R13: At most one bank is in states 3 to 6 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable sampled from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | log2(NBANK) | Bank address |
| ap | input | 1 | Auto-precharge flag on column commands; all-banks flag on precharge |
| bank_state | output | 3*NBANK | State code of bank i in bits 3i+2..3i |
| cmd_out | output | 3 | Decoded command of the previous cycle |
| err_pulse | output | 1 | One-cycle flag for a rejected command |
| err_code | output | 3 | Reason for the rejection, 0 when none |
| err_bank | output | log2(NBANK) | Bank that objected |

## Verification
Every result is a register loaded on the edge that samples the command. The decode, the error flag, its code and bank, and the new bank states are all due one cycle after the command is sampled, and the bench reads them on the falling edge that follows that edge. Timer expiries follow from the counts in the requirements: a state entered at edge k gives way at edge k+N. The bench reference model advances its own cycle counters edge by edge, so each expiry is compared in the exact cycle it falls due. The pause check also uses the two-sample rule: after `cke` returns high, one more cycle reports 7 before checking resumes.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_ACT   = 3'd2,
      CMD_RD    = 3'd3,
      CMD_WR    = 3'd4,
      CMD_PRE   = 3'd5,
      CMD_OTHER = 3'd6,
      CMD_PAUSE = 3'd7
   } bcm_cmd_e;

   typedef enum logic [2:0] {
      BS_IDLE    = 3'd0,
      BS_OPENING = 3'd1,
      BS_OPEN    = 3'd2,
      BS_RD      = 3'd3,
      BS_WR      = 3'd4,
      BS_RDAP    = 3'd5,
      BS_WRAP    = 3'd6,
      BS_CLOSING = 3'd7
   } bcm_state_e;

   typedef enum logic [2:0] {
      E_NONE     = 3'd0,
      E_NO_ROW   = 3'd1,
      E_ROW_OPEN = 3'd2,
      E_TRCD     = 3'd3,
      E_TRP      = 3'd4,
      E_WR_RECOV = 3'd5,
      E_AP_BUSY  = 3'd6,
      E_AP_CUT   = 3'd7
   } bcm_err_e;

endpackage

// File: rtl/bcm_decode.sv
module bcm_decode
   import bcm_pkg::*;
#(
   parameter int NBANK = 4,
   localparam int BA_W = $clog2(NBANK)
) (
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BA_W-1:0]  ba,
   input  logic             ap,
   output bcm_cmd_e         cmd,
   output logic [NBANK-1:0] tgt
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            default: cmd = CMD_OTHER;
         endcase
      end
   end

   // precharge with the flag set addresses every bank
   for (genvar gi = 0; gi < NBANK; gi++) begin : g_tgt
      assign tgt[gi] = ((cmd == CMD_PRE) && ap) || (ba == BA_W'(gi));
   end

endmodule

// File: rtl/bcm_bank.sv
module bcm_bank
   import bcm_pkg::*;
#(
   parameter int TRCD = 3,
   parameter int TRP  = 3,
   parameter int TWR  = 2,
   parameter int BL   = 4,
   parameter int CL   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  bcm_cmd_e   cmd,
   input  logic       tgt,
   input  logic       ap,
   input  logic       accept,
   output bcm_state_e st_q,
   output bcm_err_e   verdict
);

   localparam int RD_SPAN  = CL + BL / 2;
   localparam int RAP_SPAN = BL / 2;
   localparam int WR_SPAN  = 1 + BL / 2 + TWR;
   localparam int M1       = (TRCD > TRP) ? TRCD : TRP;
   localparam int M2       = (RD_SPAN > WR_SPAN) ? RD_SPAN : WR_SPAN;
   localparam int MAXS     = (M1 > M2) ? M1 : M2;
   localparam int CW       = $clog2(MAXS + 1);

   localparam logic [CW-1:0] C_TRCD = CW'(TRCD);
   localparam logic [CW-1:0] C_TRP  = CW'(TRP);
   localparam logic [CW-1:0] C_RD   = CW'(RD_SPAN);
   localparam logic [CW-1:0] C_RAP  = CW'(RAP_SPAN);
   localparam logic [CW-1:0] C_WR   = CW'(WR_SPAN);

   logic [CW-1:0] cnt_q, cnt_eff, cnt_d;
   bcm_state_e    st_eff, st_d;

   // age the timer: the command of this cycle is judged on the aged state
   always_comb begin
      st_eff  = st_q;
      cnt_eff = cnt_q;
      if (st_q != BS_IDLE && st_q != BS_OPEN) begin
         if (cnt_q <= CW'(1)) begin
            case (st_q)
               BS_RDAP, BS_WRAP: begin st_eff = BS_CLOSING; cnt_eff = C_TRP; end
               BS_CLOSING:       begin st_eff = BS_IDLE;    cnt_eff = '0;    end
               default:          begin st_eff = BS_OPEN;    cnt_eff = '0;    end
            endcase
         end else begin
            cnt_eff = cnt_q - CW'(1);
         end
      end
   end

   always_comb begin
      verdict = E_NONE;
      if (tgt) begin
         case (cmd)
            CMD_ACT: begin
               case (st_eff)
                  BS_IDLE:          verdict = E_NONE;
                  BS_CLOSING:       verdict = E_TRP;
                  BS_RDAP, BS_WRAP: verdict = E_AP_BUSY;
                  default:          verdict = E_ROW_OPEN;
               endcase
            end
            CMD_RD, CMD_WR: begin
               case (st_eff)
                  BS_IDLE, BS_CLOSING: verdict = E_NO_ROW;
                  BS_OPENING:          verdict = E_TRCD;
                  BS_RDAP, BS_WRAP:    verdict = E_AP_BUSY;
                  default:             verdict = E_NONE;
               endcase
            end
            CMD_PRE: begin
               case (st_eff)
                  BS_WR:            verdict = E_WR_RECOV;
                  BS_RDAP, BS_WRAP: verdict = E_AP_BUSY;
                  default:          verdict = E_NONE;
               endcase
            end
            default: verdict = E_NONE;
         endcase
      end else if ((cmd == CMD_RD || cmd == CMD_WR) &&
                   (st_eff == BS_RDAP || st_eff == BS_WRAP)) begin
         verdict = E_AP_CUT;
      end
   end

   always_comb begin
      st_d  = st_eff;
      cnt_d = cnt_eff;
      if (accept) begin
         if (tgt) begin
            case (cmd)
               CMD_ACT: begin st_d = BS_OPENING; cnt_d = C_TRCD; end
               CMD_RD: begin
                  st_d  = ap ? BS_RDAP : BS_RD;
                  cnt_d = ap ? C_RAP : C_RD;
               end
               CMD_WR: begin
                  st_d  = ap ? BS_WRAP : BS_WR;
                  cnt_d = C_WR;
               end
               CMD_PRE: begin
                  if (st_eff == BS_OPENING || st_eff == BS_OPEN || st_eff == BS_RD) begin
                     st_d  = BS_CLOSING;
                     cnt_d = C_TRP;
                  end
               end
               default: ;
            endcase
         end else if ((cmd == CMD_RD || cmd == CMD_WR) &&
                      (st_eff == BS_RD || st_eff == BS_WR)) begin
            st_d  = BS_OPEN;
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BS_IDLE;
         cnt_q <= '0;
      end else if (en) begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   // a bank only falls idle through the row-close phase
   assert_idle_via_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BS_IDLE && $past(st_q) != BS_IDLE) |-> $past(st_q) == BS_CLOSING);

   // a row opens only from a bank with no row
   assert_open_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BS_OPENING && $past(st_q) != BS_OPENING) |->
      ($past(st_q) == BS_IDLE || $past(st_q) == BS_CLOSING));

   // a column access needs a row that is open or about to be
   assert_col_needs_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == BS_RD || st_q == BS_WR || st_q == BS_RDAP || st_q == BS_WRAP) &&
       $past(st_q) != st_q) |->
      ($past(st_q) == BS_OPENING || $past(st_q) == BS_OPEN ||
       $past(st_q) == BS_RD || $past(st_q) == BS_WR));

endmodule

// File: rtl/bcm_err_pick.sv
module bcm_err_pick #(
   parameter int NBANK = 4,
   localparam int IW = $clog2(NBANK)
) (
   input  logic [NBANK-1:0][2:0] codes,
   output logic                  hit,
   output logic [2:0]            code,
   output logic [IW-1:0]         idx
);

   // lowest-numbered objecting bank wins
   always_comb begin
      code = 3'd0;
      idx  = '0;
      for (int i = NBANK - 1; i >= 0; i--) begin
         if (codes[i] != 3'd0) begin
            code = codes[i];
            idx  = IW'(i);
         end
      end
   end

   assign hit = (code != 3'd0);

endmodule

// File: rtl/bank_cmd_monitor.sv
module bank_cmd_monitor
   import bcm_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int TRCD  = 3,
   parameter int TRP   = 3,
   parameter int TWR   = 2,
   parameter int BL    = 4,
   parameter int CL    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [$clog2(NBANK)-1:0]   ba,
   input  logic                       ap,
   output logic [3*NBANK-1:0]         bank_state,
   output logic [2:0]                 cmd_out,
   output logic                       err_pulse,
   output logic [2:0]                 err_code,
   output logic [$clog2(NBANK)-1:0]   err_bank
);

   localparam int BA_W = $clog2(NBANK);

   if (NBANK < 2 || (1 << BA_W) != NBANK) begin : g_bad_nbank
      $error("NBANK must be a power of two, at least 2");
   end
   if (BL != 2 && BL != 4 && BL != 8) begin : g_bad_bl
      $error("BL must be 2, 4 or 8");
   end
   if (TRCD < 1 || TRP < 1 || TWR < 1 || CL < 1) begin : g_bad_timing
      $error("timing parameters must be at least one cycle");
   end

   logic                   cke_q;
   logic                   en;
   bcm_cmd_e               cmd;
   logic [NBANK-1:0]       tgt;
   logic [NBANK-1:0][2:0]  verd;
   logic [NBANK-1:0]       busy;
   logic                   hit;
   logic [2:0]             pick_code;
   logic [BA_W-1:0]        pick_idx;
   logic                   accept;

   assign en     = cke & cke_q;
   assign accept = ~hit;

   bcm_decode #(.NBANK(NBANK)) u_dec (
      .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba   (ba),   .ap   (ap),
      .cmd  (cmd),  .tgt  (tgt)
   );

   for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
      bcm_state_e st;
      bcm_err_e   v;
      bcm_bank #(.TRCD(TRCD), .TRP(TRP), .TWR(TWR), .BL(BL), .CL(CL)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en),
         .cmd    (cmd),
         .tgt    (tgt[gb]),
         .ap     (ap),
         .accept (accept),
         .st_q   (st),
         .verdict(v)
      );
      assign verd[gb]             = v;
      assign bank_state[3*gb +: 3] = st;
      assign busy[gb] = (st == BS_RD) || (st == BS_WR) || (st == BS_RDAP) || (st == BS_WRAP);
   end

   bcm_err_pick #(.NBANK(NBANK)) u_pick (
      .codes(verd), .hit(hit), .code(pick_code), .idx(pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_q     <= 1'b0;
         cmd_out   <= CMD_PAUSE;
         err_pulse <= 1'b0;
         err_code  <= 3'd0;
         err_bank  <= '0;
      end else begin
         cke_q     <= cke;
         cmd_out   <= en ? cmd : CMD_PAUSE;
         err_pulse <= en & hit;
         err_code  <= (en & hit) ? pick_code : 3'd0;
         err_bank  <= (en & hit) ? pick_idx : '0;
      end
   end

   assert_pause_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == CMD_PAUSE) |-> $stable(bank_state));

   assert_err_needs_cke_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(cke) && $past(cke, 2)));

   assert_one_burst_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy) <= 1);

   assert_err_coded_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_code != 3'd0 && $past(cmd_out) != CMD_PAUSE || err_code != 3'd0));

endmodule

// File: tb/bank_cmd_monitor_test.sv
`timescale 1ns/1ps
module bank_cmd_monitor_test;

   localparam int NB   = 4;
   localparam int TRCD = 3;
   localparam int TRP  = 3;
   localparam int TWR  = 2;
   localparam int BL   = 4;
   localparam int CL   = 2;
   localparam int RSPAN = CL + BL / 2;
   localparam int RAP   = BL / 2;
   localparam int WSPAN = 1 + BL / 2 + TWR;

   localparam int DESEL = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 5, OTH = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic ap = 1'b0;
   logic [3*NB-1:0] bank_state;
   logic [2:0] cmd_out;
   logic err_pulse;
   logic [2:0] err_code;
   logic [1:0] err_bank;

   always #2.5 clk = ~clk;

   bank_cmd_monitor #(.NBANK(NB), .TRCD(TRCD), .TRP(TRP), .TWR(TWR), .BL(BL), .CL(CL)) uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .bank_state(bank_state),
      .cmd_out(cmd_out), .err_pulse(err_pulse), .err_code(err_code), .err_bank(err_bank)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model
   int mst[NB];
   int mrem[NB];
   bit prev_cke = 0;
   int ex_cmd = 7, ex_err = 0, ex_code = 0, ex_bank = 0;

   function automatic int judge(int s, int c, bit t);
      if (t) begin
         if (c == ACT) return (s == 0) ? 0 : (s == 7) ? 4 : (s == 5 || s == 6) ? 6 : 2;
         if (c == RD || c == WR)
            return (s == 0 || s == 7) ? 1 : (s == 1) ? 3 : (s == 5 || s == 6) ? 6 : 0;
         if (c == PRE) return (s == 4) ? 5 : (s == 5 || s == 6) ? 6 : 0;
         return 0;
      end
      if ((c == RD || c == WR) && (s == 5 || s == 6)) return 7;
      return 0;
   endfunction

   task automatic model_edge(int c, int b, bit a, bit ck);
      bit on;
      int v[NB];
      int first;
      on = ck && prev_cke;
      prev_cke = ck;
      if (!on) begin
         ex_cmd = 7; ex_err = 0; ex_code = 0; ex_bank = 0;
         return;
      end
      for (int i = 0; i < NB; i++) begin
         if (mst[i] != 0 && mst[i] != 2) begin
            if (mrem[i] <= 1) begin
               if (mst[i] == 5 || mst[i] == 6) begin mst[i] = 7; mrem[i] = TRP; end
               else if (mst[i] == 7) begin mst[i] = 0; mrem[i] = 0; end
               else begin mst[i] = 2; mrem[i] = 0; end
            end else mrem[i]--;
         end
      end
      first = -1;
      for (int i = 0; i < NB; i++) begin
         v[i] = judge(mst[i], c, ((c == PRE) && a) || (i == b));
         if (v[i] != 0 && first < 0) first = i;
      end
      ex_cmd = c;
      if (first >= 0) begin
         ex_err = 1; ex_code = v[first]; ex_bank = first;
         return;
      end
      ex_err = 0; ex_code = 0; ex_bank = 0;
      for (int i = 0; i < NB; i++) begin
         if (((c == PRE) && a) || (i == b)) begin
            if (c == ACT) begin mst[i] = 1; mrem[i] = TRCD; end
            else if (c == RD) begin mst[i] = a ? 5 : 3; mrem[i] = a ? RAP : RSPAN; end
            else if (c == WR) begin mst[i] = a ? 6 : 4; mrem[i] = WSPAN; end
            else if (c == PRE && (mst[i] >= 1 && mst[i] <= 3)) begin mst[i] = 7; mrem[i] = TRP; end
         end else if ((c == RD || c == WR) && (mst[i] == 3 || mst[i] == 4)) begin
            mst[i] = 2; mrem[i] = 0;
         end
      end
   endtask

   task automatic set_pins(int c);
      cs_n = (c == DESEL);
      case (c)
         ACT:     {ras_n, cas_n, we_n} = 3'b011;
         RD:      {ras_n, cas_n, we_n} = 3'b101;
         WR:      {ras_n, cas_n, we_n} = 3'b100;
         PRE:     {ras_n, cas_n, we_n} = 3'b010;
         OTH:     {ras_n, cas_n, we_n} = 3'b001;
         default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
   endtask

   task automatic compare(string req);
      bit bad = 0;
      for (int i = 0; i < NB; i++)
         if (bank_state[3*i +: 3] != 3'(mst[i])) bad = 1;
      if (cmd_out != 3'(ex_cmd) || err_pulse != ex_err[0] ||
          err_code != 3'(ex_code) || err_bank != 2'(ex_bank)) bad = 1;
      n_run++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s: act st=%h cmd=%0d err=%0d code=%0d bank=%0d exp st=%0d%0d%0d%0d cmd=%0d err=%0d code=%0d bank=%0d",
                  req, bank_state, cmd_out, err_pulse, err_code, err_bank,
                  mst[3], mst[2], mst[1], mst[0], ex_cmd, ex_err, ex_code, ex_bank);
      end
   endtask

   task automatic issue(int c, int b, bit a, bit ck, string req);
      set_pins(c);
      ba  = 2'(b);
      ap  = a;
      cke = ck;
      @(posedge clk);
      model_edge(c, b, a, ck);
      @(negedge clk);
      compare(req);
   endtask

   task automatic idle_for(int n, string req);
      for (int i = 0; i < n; i++) issue(NOP, 0, 0, 1, req);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) begin mst[i] = 0; mrem[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R2 reset");
      rst_n = 1'b1;

      issue(NOP, 0, 0, 1, "R2");          // first high sample still pauses
      issue(NOP, 0, 0, 1, "R1");
      issue(DESEL, 0, 0, 1, "R1");
      issue(OTH, 2, 0, 1, "R1");
      issue(RD, 0, 0, 1, "R4");           // no row: code 1
      issue(PRE, 0, 0, 1, "R4");          // idle precharge is a no-op
      issue(ACT, 0, 0, 1, "R3");
      issue(RD, 0, 0, 1, "R3");           // too early: code 3
      issue(NOP, 0, 0, 1, "R3");
      issue(RD, 0, 0, 1, "R5");           // exactly TRCD after activate
      issue(ACT, 0, 0, 1, "R4");          // row already open: code 2
      issue(ACT, 1, 0, 1, "R9");
      idle_for(3, "R5");
      issue(RD, 0, 0, 1, "R9");
      issue(RD, 1, 0, 1, "R9");           // bank 0 read cut short
      issue(WR, 0, 0, 1, "R9");           // bank 1 read cut short
      issue(PRE, 0, 0, 1, "R5");          // write recovery: code 5
      idle_for(6, "R5");
      issue(PRE, 0, 0, 1, "R8");
      issue(ACT, 0, 0, 1, "R8");          // closing: code 4
      idle_for(4, "R8");
      issue(ACT, 0, 0, 1, "R3");
      idle_for(3, "R3");
      issue(RD, 1, 1, 1, "R6");           // read with auto-precharge
      issue(RD, 0, 0, 1, "R10");          // code 7 against bank 1
      issue(ACT, 2, 0, 1, "R10");
      idle_for(4, "R6");
      issue(WR, 0, 1, 1, "R7");           // write with auto-precharge
      issue(PRE, 0, 0, 1, "R8");          // code 6
      issue(ACT, 3, 0, 1, "R10");
      issue(WR, 2, 0, 1, "R10");          // code 7 against bank 0
      idle_for(9, "R7");
      issue(WR, 2, 0, 1, "R11");
      issue(PRE, 0, 1, 1, "R11");         // all-bank close blocked by write
      idle_for(5, "R11");
      issue(PRE, 0, 1, 1, "R11");
      idle_for(4, "R11");
      issue(ACT, 3, 0, 1, "R12");
      idle_for(3, "R12");
      issue(RD, 3, 1, 1, "R12");
      issue(RD, 0, 0, 1, "R12");          // banks 0 and 3 object, 0 reported
      idle_for(6, "R12");
      issue(ACT, 1, 0, 1, "R13");
      issue(ACT, 2, 0, 1, "R13");
      idle_for(3, "R13");
      issue(RD, 1, 0, 1, "R13");
      issue(WR, 2, 0, 1, "R13");
      issue(RD, 1, 0, 1, "R2");
      issue(NOP, 0, 0, 0, "R2");          // clock enable low: frozen
      issue(RD, 0, 0, 0, "R2");           // ignored while paused
      issue(NOP, 0, 0, 1, "R2");          // one more paused cycle
      idle_for(7, "R2");
      issue(PRE, 1, 0, 1, "R5");
      issue(PRE, 2, 0, 1, "R5");
      idle_for(4, "R6");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule